// File: doc/BRIEF.md
# Public-Key Operand Register Bank

This block stores the three wide operands of a public-key arithmetic core. Bank B holds an operand and also receives the result. Bank E holds the exponent or scalar. Bank N holds the modulus or the reduction polynomial. Each bank is a parameterised number of bits wide, 4096 by default. A host fills the banks one 64-bit word at a time through a small bus port, which has separate read and write strobes, a bank select and a word address.

The arithmetic core sees the full contents of every bank at once on wide output vectors. It writes its results back into bank B through a wide write port that has one enable per segment. In elliptic-curve mode, bank B behaves as four independent segments, and the core may update any subset of them. Outside that mode, bank B is one flat space.

Bank E is write-only from the bus. A bus read of E produces no data. Instead it raises a sticky address-error flag in a status word, and the host clears that flag by writing a one to it.

Top module: `pk_param_bank`

## Requirements
- R1: After reset, every word of B, E and N is zero, bus_rvalid_o is low and addr_err_o is low.
- R2: A bus write stores bus_wdata_i at word bus_addr_i of the selected bank. Word w appears on that bank's core output at bits [w*64 +: 64] in the cycle after the write edge.
- R3: The bank select encoding is 0 = B, 1 = E, 2 = N and 3 = status. A bus read of B or N raises bus_rvalid_o for exactly one cycle after the read edge, with the addressed word on bus_rdata_o.
- R4: A bus read of E does not raise bus_rvalid_o, and it sets addr_err_o in the following cycle. Words written to E are still visible on core_e_o.
- R5: addr_err_o stays set until a status write (select 3) with bit 0 set. A status write with bit 0 clear leaves the flag unchanged.
- R6: A bus read of the status word (select 3) returns addr_err_o in bit 0, with zeros above it, and raises bus_rvalid_o.
- R7: With ec_mode_i low, any set bit of core_we_i writes core_wdata_i over the whole of B.
- R8: With ec_mode_i high, core_we_i[s] writes only segment s of B, and unselected segments keep their contents. Segment s covers the words whose two upper address bits equal s.
- R9: A core write is dropped in any cycle in which bus_rd_i or bus_wr_i is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_rd_i | input | 1 | Bus read strobe |
| bus_sel_i | input | 2 | Bank select: 0 B, 1 E, 2 N, 3 status |
| bus_addr_i | input | ADDR_W | Word address within the bank |
| bus_wdata_i | input | WORD_W | Bus write data |
| bus_rdata_o | output | WORD_W | Bus read data |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after the strobe |
| addr_err_o | output | 1 | Sticky address-error flag |
| ec_mode_i | input | 1 | Elliptic-curve mode: segments bank B |
| core_we_i | input | SEGS | Per-segment core write enables for B |
| core_wdata_i | input | MEM_BITS | Core result data for B |
| core_b_o | output | MEM_BITS | Full contents of B |
| core_e_o | output | MEM_BITS | Full contents of E |
| core_n_o | output | MEM_BITS | Full contents of N |

## Verification
The bench builds the bank with MEM_BITS = 1024 and WORD_W = 64. That gives 16 words per bank and 4 words per segment, so the first and last word of the address space and every segment edge can be reached directly. The whole of each bank can also be compared on the core outputs against a model held in the bench. With this size, a flat-mode core write and a masked elliptic-curve write produce results that clearly differ at the segment edges.

// File: rtl/pk_bank_pkg.sv
package pk_bank_pkg;
  typedef enum logic [1:0] {
    SEL_B    = 2'd0,
    SEL_E    = 2'd1,
    SEL_N    = 2'd2,
    SEL_STAT = 2'd3
  } bank_sel_e;
endpackage

// File: rtl/pk_word_mem.sv
module pk_word_mem #(
  parameter int WORDS  = 64,
  parameter int WORD_W = 64,
  parameter int SEGS   = 4,
  localparam int ADDR_W    = $clog2(WORDS),
  localparam int SEG_WORDS = WORDS / SEGS,
  localparam int BITS      = WORDS * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              seg_mode_i,
  input  logic [SEGS-1:0]   core_we_i,
  input  logic [BITS-1:0]   core_wdata_i,
  output logic [BITS-1:0]   flat_o
);
  logic [WORDS-1:0][WORD_W-1:0] mem_q;
  logic [SEGS-1:0] seg_hit;

  // flat mode: any enable covers every segment
  always_comb seg_hit = seg_mode_i ? core_we_i : {SEGS{|core_we_i}};

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[w] <= '0;
      else if (we_i && addr_i == ADDR_W'(w)) mem_q[w] <= wdata_i;
      else if (seg_hit[w / SEG_WORDS]) mem_q[w] <= core_wdata_i[w*WORD_W +: WORD_W];
    end
  end

  assign flat_o = mem_q;

  // R2
  bus_write_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(addr_i)] == $past(wdata_i));
endmodule

// File: rtl/pk_err_status.sv
module pk_err_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic err_o
);
  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    err_q <= 1'b0;
    else if (set_i) err_q <= 1'b1;
    else if (clr_i) err_q <= 1'b0;
  end

  assign err_o = err_q;

  // R4
  err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> err_o);
  // R5
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clr_i) |=> err_o);
  // R5
  err_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !err_o);
endmodule

// File: rtl/pk_param_bank.sv
module pk_param_bank
  import pk_bank_pkg::*;
#(
  parameter int MEM_BITS = 4096,
  parameter int WORD_W   = 64,
  parameter int SEGS     = 4,
  localparam int WORDS  = MEM_BITS / WORD_W,
  localparam int ADDR_W = $clog2(WORDS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_wr_i,
  input  logic                bus_rd_i,
  input  logic [1:0]          bus_sel_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [WORD_W-1:0]   bus_wdata_i,
  output logic [WORD_W-1:0]   bus_rdata_o,
  output logic                bus_rvalid_o,
  output logic                addr_err_o,
  input  logic                ec_mode_i,
  input  logic [SEGS-1:0]     core_we_i,
  input  logic [MEM_BITS-1:0] core_wdata_i,
  output logic [MEM_BITS-1:0] core_b_o,
  output logic [MEM_BITS-1:0] core_e_o,
  output logic [MEM_BITS-1:0] core_n_o
);
  bank_sel_e sel;
  logic      we_b, we_e, we_n, clr_err, rd_e, rd_ok, bus_busy;
  logic [SEGS-1:0]   core_we_g;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] rdata_q;
  logic              rvalid_q;

  assign sel      = bank_sel_e'(bus_sel_i);
  assign we_b     = bus_wr_i && sel == SEL_B;
  assign we_e     = bus_wr_i && sel == SEL_E;
  assign we_n     = bus_wr_i && sel == SEL_N;
  assign clr_err  = bus_wr_i && sel == SEL_STAT && bus_wdata_i[0];
  assign rd_e     = bus_rd_i && sel == SEL_E;
  assign rd_ok    = bus_rd_i && sel != SEL_E;
  assign bus_busy = bus_rd_i || bus_wr_i;
  // core only writes back while the bus is quiet
  assign core_we_g = bus_busy ? '0 : core_we_i;

  pk_word_mem #(.WORDS(WORDS), .WORD_W(WORD_W), .SEGS(SEGS)) u_mem_b (
    .clk_i, .rst_ni, .we_i(we_b), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .seg_mode_i(ec_mode_i), .core_we_i(core_we_g), .core_wdata_i(core_wdata_i),
    .flat_o(core_b_o));

  pk_word_mem #(.WORDS(WORDS), .WORD_W(WORD_W), .SEGS(SEGS)) u_mem_e (
    .clk_i, .rst_ni, .we_i(we_e), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .seg_mode_i(1'b0), .core_we_i('0), .core_wdata_i('0), .flat_o(core_e_o));

  pk_word_mem #(.WORDS(WORDS), .WORD_W(WORD_W), .SEGS(SEGS)) u_mem_n (
    .clk_i, .rst_ni, .we_i(we_n), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .seg_mode_i(1'b0), .core_we_i('0), .core_wdata_i('0), .flat_o(core_n_o));

  pk_err_status u_err (
    .clk_i, .rst_ni, .set_i(rd_e), .clr_i(clr_err), .err_o(addr_err_o));

  always_comb begin
    unique case (sel)
      SEL_B:    rd_word = core_b_o[bus_addr_i*WORD_W +: WORD_W];
      SEL_N:    rd_word = core_n_o[bus_addr_i*WORD_W +: WORD_W];
      SEL_STAT: rd_word = {{(WORD_W-1){1'b0}}, addr_err_o};
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_ok;
      if (rd_ok) rdata_q <= rd_word;
    end
  end

  assign bus_rdata_o  = rdata_q;
  assign bus_rvalid_o = rvalid_q;

  // R3
  rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && bus_sel_i != 2'd1) |=> bus_rvalid_o);
  // R4
  e_rd_no_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && bus_sel_i == 2'd1) |=> !bus_rvalid_o);
  // R3
  rvalid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |=> !bus_rvalid_o);
  // R9
  core_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && !bus_wr_i) |=> $stable(core_b_o));
endmodule

// File: tb/pk_param_bank_tb_top.sv
module pk_param_bank_tb_top;
  localparam int MEM_BITS = 1024;
  localparam int WORD_W   = 64;
  localparam int SEGS     = 4;
  localparam int WORDS    = MEM_BITS / WORD_W;
  localparam int ADDR_W   = $clog2(WORDS);
  localparam int SEG_W    = WORDS / SEGS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0, ec_mode = 0;
  logic [1:0] bus_sel = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [WORD_W-1:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid, addr_err;
  logic [SEGS-1:0] core_we = '0;
  logic [MEM_BITS-1:0] core_wdata = '0, core_b, core_e, core_n;

  int total = 0, bad = 0;
  bit done = 0;
  logic [WORD_W-1:0] exp_q[$];
  string tag_q[$];
  logic [WORDS-1:0][WORD_W-1:0] b_m, e_m, n_m;

  always #5 clk = ~clk;

  pk_param_bank #(.MEM_BITS(MEM_BITS), .WORD_W(WORD_W), .SEGS(SEGS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_sel_i(bus_sel), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .bus_rvalid_o(bus_rvalid), .addr_err_o(addr_err),
    .ec_mode_i(ec_mode), .core_we_i(core_we), .core_wdata_i(core_wdata),
    .core_b_o(core_b), .core_e_o(core_e), .core_n_o(core_n));

  task automatic check(input bit ok, input string tag, input logic [MEM_BITS-1:0] act,
                       input logic [MEM_BITS-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pop expected read data as valid pulses arrive
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) check(1'b0, "R3 unexpected rvalid", bus_rdata, '0);
      else begin
        automatic logic [WORD_W-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(bus_rdata === e, t, bus_rdata, e);
      end
    end
  end

  task automatic bus_write(input logic [1:0] sel, input int a, input logic [WORD_W-1:0] d);
    bus_wr = 1; bus_sel = sel; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
    case (sel)
      2'd0: b_m[a] = d;
      2'd1: e_m[a] = d;
      2'd2: n_m[a] = d;
      default: ;
    endcase
  endtask

  task automatic bus_read(input logic [1:0] sel, input int a, input logic [WORD_W-1:0] e,
                          input string t);
    if (sel != 2'd1) begin exp_q.push_back(e); tag_q.push_back(t); end
    bus_rd = 1; bus_sel = sel; bus_addr = ADDR_W'(a);
    @(negedge clk);
    bus_rd = 0;
  endtask

  function automatic logic [MEM_BITS-1:0] pattern(input logic [31:0] seed);
    logic [MEM_BITS-1:0] p;
    for (int i = 0; i < WORDS; i++) p[i*WORD_W +: WORD_W] = {seed, 32'(i) ^ 32'h5a5a0000};
    return p;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [MEM_BITS-1:0] p;
    b_m = '0; e_m = '0; n_m = '0;
    repeat (2) @(negedge clk);
    // R1
    check(core_b === '0 && core_e === '0 && core_n === '0, "R1 banks zero", core_b | core_e | core_n, '0);
    check(bus_rvalid === 1'b0 && addr_err === 1'b0, "R1 flags low", {bus_rvalid, addr_err}, '0);
    rst_n = 1;
    @(negedge clk);

    // R2: writes at edges of the space
    bus_write(2'd0, 0, 64'h0123_4567_89ab_cdef);
    bus_write(2'd0, WORDS-1, 64'hfeed_face_cafe_beef);
    bus_write(2'd0, 5, 64'h1111_2222_3333_4444);
    bus_write(2'd2, 3, 64'hdead_0000_0000_0003);
    bus_write(2'd1, 7, 64'h0e0e_0e0e_0e0e_0e07);
    check(core_b === MEM_BITS'(b_m), "R2 bank B image", core_b, b_m);
    check(core_n === MEM_BITS'(n_m), "R2 bank N image", core_n, n_m);

    // R3: reads of B and N via scoreboard
    bus_read(2'd0, 0, b_m[0], "R3 read B word 0");
    bus_read(2'd0, WORDS-1, b_m[WORDS-1], "R3 read B last word");
    bus_read(2'd2, 3, n_m[3], "R3 read N word 3");
    bus_read(2'd2, 4, 64'h0, "R3 read N unwritten");
    @(negedge clk);
    check(bus_rvalid === 1'b0, "R3 rvalid single pulse", bus_rvalid, 0);

    // R4: E read rejected
    bus_read(2'd1, 7, '0, "");
    check(bus_rvalid === 1'b0, "R4 no rvalid on E read", bus_rvalid, 0);
    check(addr_err === 1'b1, "R4 error set", addr_err, 1);
    check(core_e === MEM_BITS'(e_m), "R4 E visible to core", core_e, e_m);

    // R6 / R5
    bus_read(2'd3, 0, 64'h1, "R6 status shows error");
    bus_write(2'd3, 0, 64'hffff_ffff_ffff_fffe);
    check(addr_err === 1'b1, "R5 bit0 clear keeps flag", addr_err, 1);
    repeat (3) @(negedge clk);
    check(addr_err === 1'b1, "R5 flag sticky", addr_err, 1);
    bus_write(2'd3, 0, 64'h1);
    check(addr_err === 1'b0, "R5 flag cleared", addr_err, 0);
    bus_read(2'd3, 0, 64'h0, "R6 status clear");
    @(negedge clk);

    // R7: flat mode, single enable writes everything
    p = pattern(32'ha000_0001);
    ec_mode = 0; core_we = 4'b0010; core_wdata = p;
    @(negedge clk);
    core_we = '0;
    b_m = p;
    check(core_b === MEM_BITS'(b_m), "R7 flat core write", core_b, b_m);

    // R8: segmented mode, segments 0 and 2 only
    p = pattern(32'hb000_0002);
    ec_mode = 1; core_we = 4'b0101; core_wdata = p;
    @(negedge clk);
    core_we = '0;
    for (int s = 0; s < SEGS; s++)
      if (s == 0 || s == 2)
        for (int w = s*SEG_W; w < (s+1)*SEG_W; w++) b_m[w] = p[w*WORD_W +: WORD_W];
    check(core_b === MEM_BITS'(b_m), "R8 masked segment write", core_b, b_m);
    bus_read(2'd0, 2*SEG_W, b_m[2*SEG_W], "R8 first word seg 2");
    bus_read(2'd0, 2*SEG_W-1, b_m[2*SEG_W-1], "R8 last word seg 1 kept");
    bus_read(2'd0, WORDS-1, b_m[WORDS-1], "R8 last word seg 3 kept");

    // R9: core write colliding with bus read is dropped
    p = pattern(32'hc000_0003);
    core_we = 4'b1111; core_wdata = p;
    bus_read(2'd2, 3, n_m[3], "R9 colliding read of N");
    core_we = '0;
    check(core_b === MEM_BITS'(b_m), "R9 core write dropped", core_b, b_m);
    ec_mode = 0;
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R3 all reads returned", exp_q.size(), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule